// File: doc/BRIEF.md
# DMA Channel Interrupt Status Register

This block collects the interrupt sources of one DMA channel into a sticky status register. The sources are: descriptor completion on the read and write sides, overflow of the byte counter and of the two accounting counters, bus errors during descriptor fetch, bus errors on the data path, completion of the whole transfer, entry into the pause state, and parity errors from three internal memories. Software reads the status word and clears bits by writing ones to them. A mask register selects which status bits drive the single registered interrupt line.

Data-path bus errors are fatal. Such an error is held internally while an external engine recovers the occupied buffer entries. Its status bit is posted only when the engine signals that recovery is done, and the channel-disable output rises in the same cycle. All other sources are non-fatal and leave the channel enabled. Register access is a plain word-addressed port: the write takes effect on the clock edge, and the read data is combinational from the selected register.

Top module: `dma_chan_irq_stat`

## Requirements
- R1: After reset the status word, the mask word, `irq_o` and `chan_dis_o` are all zero.
- R2: A source-descriptor completion pulse sets status bit 1, and a destination-descriptor completion pulse sets bit 2. Status is read at word address `STAT_OFS` (0) and the mask at `MASK_OFS` (1).
- R3: Byte-count overflow sets bit 3, source accounting overflow sets bit 4, and destination accounting overflow sets bit 5. None of these raises `chan_dis_o`.
- R4: A source descriptor fetch error sets bit 6 and a destination descriptor fetch error sets bit 7. Neither raises `chan_dis_o`.
- R5: A read-data error or write-data error alone sets nothing. Bit 8 (read) or bit 9 (write) is set on the edge where `recov_done_i` is high, either after the error or in the same cycle as it. `chan_dis_o` rises on that same edge.
- R6: `chan_dis_o` stays high while bit 8 or bit 9 is set, and falls once both have been cleared.
- R7: Transfer completion sets bit 10. A pause entry sets bit 11 only when `pause_irq_en_i` is high.
- R8: `ram_perr_i[0]` (data buffer), `[1]` (free-slot list) and `[2]` (linked list) set status bits 12, 13 and 14.
- R9: Status bits are sticky and are cleared only by writing 1 to them at `STAT_OFS`. Writing 0 leaves a bit unchanged. A set event in the same cycle as a clear leaves the bit set.
- R10: Status and mask bits 0 and 15 and above always read as zero. Writing ones to them has no effect.
- R11: `irq_o` is the OR of (status AND mask), registered. It changes one clock edge after the status or mask change.
- R12: Addresses other than `STAT_OFS` and `MASK_OFS` read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_dscr_done_i | input | 1 | Source descriptor finished (pulse) |
| dst_dscr_done_i | input | 1 | Destination descriptor finished (pulse) |
| byte_ovf_i | input | 1 | Byte counter exceeded the requested size |
| src_acct_ovf_i | input | 1 | Source accounting counter overflow |
| dst_acct_ovf_i | input | 1 | Destination accounting counter overflow |
| src_fetch_err_i | input | 1 | Bus error while fetching a source descriptor |
| dst_fetch_err_i | input | 1 | Bus error while fetching a destination descriptor |
| rd_data_err_i | input | 1 | Bus error on a data read |
| wr_data_err_i | input | 1 | Bus error on a data write |
| recov_done_i | input | 1 | External buffer recovery finished |
| xfer_done_i | input | 1 | Whole transfer finished |
| pause_enter_i | input | 1 | Channel entered the pause state |
| pause_irq_en_i | input | 1 | Allows pause entry to set its status bit |
| ram_perr_i | input | 3 | Parity errors: buffer, free list, linked list |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |
| irq_o | output | 1 | Registered interrupt request |
| chan_dis_o | output | 1 | Channel disable after a fatal data error |

## Verification
The bench builds the block with its defaults: a 32-bit data word and a 4-bit address. With these, the upper 17 bits of the read word and the unmapped addresses 2 to 15 can be written with all ones, so the bench can show they stay zero. Both address offsets keep their default values, so the checks cover the decode of status against mask and the fall-through to zero on every other address.

// File: rtl/dcis_pkg.sv
package dcis_pkg;
  localparam int STAT_W = 15;

  localparam int B_SRC_DONE = 1;
  localparam int B_DST_DONE = 2;
  localparam int B_BYTE_OVF = 3;
  localparam int B_SRC_ACCT = 4;
  localparam int B_DST_ACCT = 5;
  localparam int B_SRC_FETCH = 6;
  localparam int B_DST_FETCH = 7;
  localparam int B_RD_DATA = 8;
  localparam int B_WR_DATA = 9;
  localparam int B_XFER_DONE = 10;
  localparam int B_PAUSE = 11;
  localparam int B_PERR_BUF = 12;
  localparam int B_PERR_FREE = 13;
  localparam int B_PERR_LINK = 14;

  // bit 0 is reserved; every other bit below STAT_W is backed by a flop
  localparam logic [STAT_W-1:0] IMPL_MASK = 15'h7FFE;
endpackage

// File: rtl/dcis_sticky_bit.sv
module dcis_sticky_bit #(
  parameter bit IMPL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;
  logic q_nxt;
  logic q_en;

  // set wins over clear; a reserved position never leaves zero
  always_comb begin
    q_en  = set_i | clr_i;
    q_nxt = IMPL & (set_i | (q_q & ~clr_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= 1'b0;
    else if (q_en) q_q <= q_nxt;
  end

  assign q_o = q_q;
endmodule

// File: rtl/dcis_fatal_gate.sv
module dcis_fatal_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_err_i,
  input  logic wr_err_i,
  input  logic recov_done_i,
  output logic rd_set_o,
  output logic wr_set_o
);
  logic rd_pend_q, rd_pend_nxt;
  logic wr_pend_q, wr_pend_nxt;
  logic pend_en;

  // an error waits here until recovery reports completion
  always_comb begin
    rd_set_o    = recov_done_i & (rd_pend_q | rd_err_i);
    wr_set_o    = recov_done_i & (wr_pend_q | wr_err_i);
    rd_pend_nxt = (rd_pend_q | rd_err_i) & ~recov_done_i;
    wr_pend_nxt = (wr_pend_q | wr_err_i) & ~recov_done_i;
    pend_en     = rd_err_i | wr_err_i | recov_done_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      wr_pend_q <= 1'b0;
    end else if (pend_en) begin
      rd_pend_q <= rd_pend_nxt;
      wr_pend_q <= wr_pend_nxt;
    end
  end
endmodule

// File: rtl/dcis_regport.sv
module dcis_regport #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int STAT_OFS = 0,
  parameter int MASK_OFS = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          reg_addr_i,
  input  logic                       reg_wr_i,
  input  logic [DATA_W-1:0]          reg_wdata_i,
  input  logic [dcis_pkg::STAT_W-1:0] stat_i,
  output logic [dcis_pkg::STAT_W-1:0] clr_o,
  output logic [dcis_pkg::STAT_W-1:0] mask_o,
  output logic [DATA_W-1:0]          reg_rdata_o
);
  localparam int SW = dcis_pkg::STAT_W;

  logic          sel_stat;
  logic          sel_mask;
  logic          mask_en;
  logic [SW-1:0] mask_q;
  logic [SW-1:0] mask_nxt;
  logic          unused_wdata_hi;

  always_comb begin
    sel_stat = (reg_addr_i == ADDR_W'(STAT_OFS));
    sel_mask = (reg_addr_i == ADDR_W'(MASK_OFS));
    clr_o    = (reg_wr_i && sel_stat) ? reg_wdata_i[SW-1:0] : '0;
    mask_en  = reg_wr_i && sel_mask;
    mask_nxt = reg_wdata_i[SW-1:0] & dcis_pkg::IMPL_MASK;
    if (sel_stat)      reg_rdata_o = DATA_W'(stat_i);
    else if (sel_mask) reg_rdata_o = DATA_W'(mask_q);
    else               reg_rdata_o = '0;
  end

  assign unused_wdata_hi = ^reg_wdata_i[DATA_W-1:SW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_nxt;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/dma_chan_irq_stat.sv
module dma_chan_irq_stat #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int STAT_OFS = 0,
  parameter int MASK_OFS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_dscr_done_i,
  input  logic              dst_dscr_done_i,
  input  logic              byte_ovf_i,
  input  logic              src_acct_ovf_i,
  input  logic              dst_acct_ovf_i,
  input  logic              src_fetch_err_i,
  input  logic              dst_fetch_err_i,
  input  logic              rd_data_err_i,
  input  logic              wr_data_err_i,
  input  logic              recov_done_i,
  input  logic              xfer_done_i,
  input  logic              pause_enter_i,
  input  logic              pause_irq_en_i,
  input  logic [2:0]        ram_perr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              chan_dis_o
);
  import dcis_pkg::*;

  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] mask_q;
  logic              rd_set;
  logic              wr_set;
  logic              irq_q;
  logic              irq_nxt;

  dcis_fatal_gate i_fatal (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_err_i     (rd_data_err_i),
    .wr_err_i     (wr_data_err_i),
    .recov_done_i (recov_done_i),
    .rd_set_o     (rd_set),
    .wr_set_o     (wr_set)
  );

  always_comb begin
    set_vec              = '0;
    set_vec[B_SRC_DONE]  = src_dscr_done_i;
    set_vec[B_DST_DONE]  = dst_dscr_done_i;
    set_vec[B_BYTE_OVF]  = byte_ovf_i;
    set_vec[B_SRC_ACCT]  = src_acct_ovf_i;
    set_vec[B_DST_ACCT]  = dst_acct_ovf_i;
    set_vec[B_SRC_FETCH] = src_fetch_err_i;
    set_vec[B_DST_FETCH] = dst_fetch_err_i;
    set_vec[B_RD_DATA]   = rd_set;
    set_vec[B_WR_DATA]   = wr_set;
    set_vec[B_XFER_DONE] = xfer_done_i;
    set_vec[B_PAUSE]     = pause_enter_i & pause_irq_en_i;
    set_vec[B_PERR_BUF]  = ram_perr_i[0];
    set_vec[B_PERR_FREE] = ram_perr_i[1];
    set_vec[B_PERR_LINK] = ram_perr_i[2];
  end

  for (genvar gi = 0; gi < STAT_W; gi++) begin : g_stat
    dcis_sticky_bit #(.IMPL(IMPL_MASK[gi])) i_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec[gi]),
      .clr_i (clr_vec[gi]),
      .q_o   (stat_q[gi])
    );
  end

  dcis_regport #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .STAT_OFS (STAT_OFS),
    .MASK_OFS (MASK_OFS)
  ) i_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr_i  (reg_addr_i),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .stat_i      (stat_q),
    .clr_o       (clr_vec),
    .mask_o      (mask_q),
    .reg_rdata_o (reg_rdata_o)
  );

  always_comb irq_nxt = |(stat_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_nxt;
  end

  assign irq_o      = irq_q;
  assign chan_dis_o = stat_q[B_RD_DATA] | stat_q[B_WR_DATA];
endmodule

// File: rtl/dcis_checker.sv
module dcis_checker #(
  parameter int ADDR_W   = 4,
  parameter int STAT_OFS = 0
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        recov_done_i,
  input logic                        pause_enter_i,
  input logic                        pause_irq_en_i,
  input logic                        reg_wr_i,
  input logic [ADDR_W-1:0]           reg_addr_i,
  input logic [dcis_pkg::STAT_W-1:0] wdata_lo,
  input logic [dcis_pkg::STAT_W-1:0] stat_q,
  input logic [dcis_pkg::STAT_W-1:0] mask_q,
  input logic                        irq_o,
  input logic                        chan_dis_o
);
  // R5: fatal data bits appear only on a recovery-done edge
  a_r5_rd_after_recov: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[8]) |-> $past(recov_done_i));
  a_r5_wr_after_recov: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[9]) |-> $past(recov_done_i));

  // R3 and R4: disable only ever follows a recovery, never an overflow or fetch error
  a_r3_dis_needs_recov: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chan_dis_o) |-> $past(recov_done_i));

  // R7: pause bit needs its enable
  a_r7_pause_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[11]) |-> $past(pause_enter_i && pause_irq_en_i));

  // R10: reserved position stays clear
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_q[0] && !mask_q[0]);

  // R11: interrupt lags the masked status by one edge
  a_r11_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|(stat_q & mask_q)));

  // R9: a bit drops only after a one was written to it
  for (genvar b = 0; b < dcis_pkg::STAT_W; b++) begin : g_w1c
    a_r9_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_q[b]) |->
        $past(reg_wr_i && (reg_addr_i == ADDR_W'(STAT_OFS)) && wdata_lo[b]));
  end
endmodule

bind dma_chan_irq_stat dcis_checker #(
  .ADDR_W   (ADDR_W),
  .STAT_OFS (STAT_OFS)
) i_dcis_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .recov_done_i   (recov_done_i),
  .pause_enter_i  (pause_enter_i),
  .pause_irq_en_i (pause_irq_en_i),
  .reg_wr_i       (reg_wr_i),
  .reg_addr_i     (reg_addr_i),
  .wdata_lo       (reg_wdata_i[dcis_pkg::STAT_W-1:0]),
  .stat_q         (stat_q),
  .mask_q         (mask_q),
  .irq_o          (irq_o),
  .chan_dis_o     (chan_dis_o)
);

// File: tb/test_dma_chan_irq_stat.sv
module test_dma_chan_irq_stat;
  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk;
  logic          rst_n;
  logic [15:0]   ev;
  logic          recov;
  logic          pause_en;
  logic [AW-1:0] addr;
  logic          wr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          irq;
  logic          dis;

  int n_run  = 0;
  int n_fail = 0;

  dma_chan_irq_stat #(.DATA_W(DW), .ADDR_W(AW)) i_dma_chan_irq_stat (
    .clk             (clk),
    .rst_n           (rst_n),
    .src_dscr_done_i (ev[1]),
    .dst_dscr_done_i (ev[2]),
    .byte_ovf_i      (ev[3]),
    .src_acct_ovf_i  (ev[4]),
    .dst_acct_ovf_i  (ev[5]),
    .src_fetch_err_i (ev[6]),
    .dst_fetch_err_i (ev[7]),
    .rd_data_err_i   (ev[8]),
    .wr_data_err_i   (ev[9]),
    .recov_done_i    (recov),
    .xfer_done_i     (ev[10]),
    .pause_enter_i   (ev[11]),
    .pause_irq_en_i  (pause_en),
    .ram_perr_i      (ev[14:12]),
    .reg_addr_i      (addr),
    .reg_wr_i        (wr),
    .reg_wdata_i     (wdata),
    .reg_rdata_o     (rdata),
    .irq_o           (irq),
    .chan_dis_o      (dis)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic pulse(input logic [15:0] e, input logic rc);
    ev = e; recov = rc;
    @(negedge clk);
    ev = '0; recov = 1'b0;
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [15:0] e);
    addr = a; wdata = d; wr = 1'b1; ev = e;
    @(negedge clk);
    wr = 1'b0; wdata = '0; ev = '0; addr = '0;
  endtask

  task automatic rd_reg(input logic [AW-1:0] a, output logic [DW-1:0] d);
    addr = a;
    #1 d = rdata;
    addr = '0;
  endtask

  task automatic clear_all();
    wr_reg(0, 32'hFFFF_FFFF, '0);
    wr_reg(1, 32'h0, '0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    rd_reg(0, d); check("R1 status", d, 0);
    rd_reg(1, d); check("R1 mask", d, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 dis", {31'b0, dis}, 0);
  endtask

  task automatic t_dscr_done();
    logic [DW-1:0] d;
    pulse(16'h0002, 0); rd_reg(0, d); check("R2 src done", d, 32'h2);
    pulse(16'h0004, 0); rd_reg(0, d); check("R2 dst done", d, 32'h6);
    clear_all();
  endtask

  task automatic t_nonfatal();
    logic [DW-1:0] d;
    pulse(16'h0038, 0); rd_reg(0, d); check("R3 overflow bits", d, 32'h38);
    check("R3 no disable", {31'b0, dis}, 0);
    pulse(16'h00C0, 0); rd_reg(0, d); check("R4 fetch bits", d, 32'hF8);
    check("R4 no disable", {31'b0, dis}, 0);
    clear_all();
  endtask

  task automatic t_fatal();
    logic [DW-1:0] d;
    pulse(16'h0100, 0);
    repeat (3) @(negedge clk);
    rd_reg(0, d); check("R5 held before recovery", d, 0);
    check("R5 no early disable", {31'b0, dis}, 0);
    pulse(16'h0000, 1);
    rd_reg(0, d); check("R5 read err posted", d, 32'h100);
    check("R5 disable with post", {31'b0, dis}, 1);
    pulse(16'h0200, 1);
    rd_reg(0, d); check("R5 write err same-cycle recovery", d, 32'h300);
    wr_reg(0, 32'h100, '0);
    check("R6 disable held by bit 9", {31'b0, dis}, 1);
    wr_reg(0, 32'h200, '0);
    check("R6 disable released", {31'b0, dis}, 0);
    pulse(16'h0000, 1);
    rd_reg(0, d); check("R5 recovery alone posts nothing", d, 0);
    clear_all();
  endtask

  task automatic t_done_pause();
    logic [DW-1:0] d;
    pulse(16'h0400, 0); rd_reg(0, d); check("R7 transfer done", d, 32'h400);
    pause_en = 1'b0;
    pulse(16'h0800, 0); rd_reg(0, d); check("R7 pause gated off", d, 32'h400);
    pause_en = 1'b1;
    pulse(16'h0800, 0); rd_reg(0, d); check("R7 pause posted", d, 32'hC00);
    pause_en = 1'b0;
    clear_all();
  endtask

  task automatic t_parity();
    logic [DW-1:0] d;
    pulse(16'h2000, 0); rd_reg(0, d); check("R8 free list", d, 32'h2000);
    pulse(16'h5000, 0); rd_reg(0, d); check("R8 all memories", d, 32'h7000);
    clear_all();
  endtask

  task automatic t_w1c();
    logic [DW-1:0] d;
    pulse(16'h0046, 0);
    repeat (2) @(negedge clk);
    rd_reg(0, d); check("R9 sticky", d, 32'h46);
    wr_reg(0, 32'h0, '0); rd_reg(0, d); check("R9 zero write", d, 32'h46);
    wr_reg(0, 32'h4, '0); rd_reg(0, d); check("R9 single clear", d, 32'h42);
    wr_reg(0, 32'h42, 16'h0002); rd_reg(0, d); check("R9 set beats clear", d, 32'h2);
    clear_all();
  endtask

  task automatic t_reserved();
    logic [DW-1:0] d;
    wr_reg(1, 32'hFFFF_FFFF, '0); rd_reg(1, d); check("R10 mask reserved", d, 32'h7FFE);
    pulse(16'hFFFF, 0); rd_reg(0, d);
    // bits 8, 9, 11 need recovery or pause enable, so they stay clear
    check("R10 status reserved", d, 32'h74FE);
    clear_all();
  endtask

  task automatic t_irq();
    wr_reg(1, 32'h2, '0);
    pulse(16'h0002, 0);
    check("R11 irq lags", {31'b0, irq}, 0);
    @(negedge clk);
    check("R11 irq raised", {31'b0, irq}, 1);
    wr_reg(0, 32'h2, '0);
    check("R11 irq lags clear", {31'b0, irq}, 1);
    @(negedge clk);
    check("R11 irq dropped", {31'b0, irq}, 0);
    pulse(16'h0004, 0);
    @(negedge clk);
    check("R11 masked source", {31'b0, irq}, 0);
    wr_reg(1, 32'h4, '0);
    @(negedge clk);
    check("R11 mask enable raises", {31'b0, irq}, 1);
    clear_all();
  endtask

  task automatic t_addr();
    logic [DW-1:0] d;
    pulse(16'h0008, 0);
    wr_reg(5, 32'hFFFF_FFFF, '0);
    wr_reg(15, 32'hFFFF_FFFF, '0);
    rd_reg(5, d); check("R12 unmapped read", d, 0);
    rd_reg(0, d); check("R12 status untouched", d, 32'h8);
    rd_reg(1, d); check("R12 mask untouched", d, 0);
    clear_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ev = '0; recov = 1'b0; pause_en = 1'b0;
    addr = '0; wr = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dscr_done();
    t_nonfatal();
    t_fatal();
    t_done_pause();
    t_parity();
    t_w1c();
    t_reserved();
    t_irq();
    t_addr();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule